// File: doc/BRIEF.md
# Super I/O Configuration Port Controller

This block is the configuration front end of a small legacy peripheral controller that hosts one parallel port and two serial ports. The host reaches it through two byte-wide I/O locations: an index port and, one address above it, a data port. The register space is flat and has no logical-device select. Every setting of all three ports lives in one map of byte registers, and some registers hold fields for more than one port.

Configuration is locked after reset. Writing the opening key 0x55 to the index port unlocks it, and writing the closing key 0xAA to the index port locks it again. While unlocked, an index write selects a register and data-port accesses read or write it. The block turns the stored settings into per-port outputs: a decoded I/O base address, an interrupt number, a DMA channel for the parallel port, and an active flag. It also decodes the live host address into one chip select per port. Those selects drive the port logic, which is not part of this block.

Top module: `sio_cfg_port`

## Requirements
- R1: After reset, configuration is locked. Every base, IRQ, DMA and power register is zero, so all base, IRQ and DRQ outputs are zero, and every active flag and chip select is low.
- R2: While locked, a write of 0x55 to the index port unlocks configuration. Any other index-port write is ignored. Data-port writes are ignored, and data-port reads return 0xFF.
- R3: While unlocked, a write of 0xAA to the index port locks configuration and leaves the selected index unchanged, so register 0xAA is never selected. Data-port writes after that are ignored.
- R4: Index 0x23 holds the parallel base, 0x24 the first serial base and 0x25 the second serial base, each as the address divided by four. The base output equals the register value shifted left by two.
- R5: Index 0x26 bits [3:0] give the parallel DRQ number. All eight bits are stored and read back unchanged.
- R6: Index 0x27 bits [3:0] give the parallel IRQ. Index 0x28 bits [7:4] give the first serial IRQ, and bits [3:0] give the second serial IRQ.
- R7: Index 0x01 bit 2 powers the parallel port. Index 0x02 bit 3 powers the first serial port, and bit 7 powers the second. Both registers store and return all eight bits.
- R8: A port's active flag is high only when its power bit is set and its base register is nonzero.
- R9: A chip select is high only while its port is active and the host address lies inside the port's window. The window is 4 bytes from the base for the parallel port and 8 bytes from the base for each serial port.
- R10: Data-port reads of an index that has no register return 0x00. Writes to such an index change no register.
- R11: An index-port read returns the selected index while unlocked and 0xFF while locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| hostAddr | input | 16 | Host I/O address, used for the port accesses and for chip-select decode |
| hostWr | input | 1 | Host write strobe, one cycle per byte |
| hostRd | input | 1 | Host read strobe; the read data is combinational |
| hostWdata | input | 8 | Host write byte |
| hostRdata | output | 8 | Read byte; 0x00 when no read is active or the address is not a configuration port |
| ppBase | output | 16 | Parallel port base address |
| sp1Base | output | 16 | First serial port base address |
| sp2Base | output | 16 | Second serial port base address |
| ppIrq | output | 4 | Parallel port IRQ number |
| sp1Irq | output | 4 | First serial port IRQ number |
| sp2Irq | output | 4 | Second serial port IRQ number |
| ppDrq | output | 4 | Parallel port DMA channel |
| ppActive | output | 1 | Parallel port powered and based |
| sp1Active | output | 1 | First serial port powered and based |
| sp2Active | output | 1 | Second serial port powered and based |
| ppSel | output | 1 | Parallel port chip select |
| sp1Sel | output | 1 | First serial port chip select |
| sp2Sel | output | 1 | Second serial port chip select |

## Verification
The hardest case to reach from the ports is whether 0xAA really relocks the block instead of selecting register 0xAA. The pins cannot see the internal index directly. The stimulus first selects index 0x28 and then writes the closing key. A data write that follows must then leave the serial IRQ outputs unchanged. After the block is unlocked again, the index-port read must still return 0x28. Locked-mode writes are exposed the same way: after the next unlock, a read of the index and of the target register shows that neither was touched.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;
  localparam int NUM_DEV = 3;
  localparam int DEV_PP  = 0;
  localparam int DEV_SP1 = 1;
  localparam int DEV_SP2 = 2;

  localparam logic [7:0] KEY_OPEN  = 8'h55;
  localparam logic [7:0] KEY_CLOSE = 8'hAA;

  localparam logic [7:0] IDX_PWR_A   = 8'h01;
  localparam logic [7:0] IDX_PWR_B   = 8'h02;
  localparam logic [7:0] IDX_BASE0   = 8'h23;
  localparam logic [7:0] IDX_DMA_PP  = 8'h26;
  localparam logic [7:0] IDX_IRQ_PP  = 8'h27;
  localparam logic [7:0] IDX_IRQ_SP  = 8'h28;

  // Strobe bundle from control to datapath
  typedef struct packed {
    logic       wrEn;
    logic [7:0] idx;
    logic [7:0] wdata;
  } cfgCmd_t;
endpackage

// File: rtl/sio_cfg_ctrl.sv
module sio_cfg_ctrl
  import sio_cfg_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] CFG_PORT = 'h2E
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              hostWr,
  input  logic              hostRd,
  input  logic [7:0]        hostWdata,
  input  logic [7:0]        regRdata,
  output cfgCmd_t           cfgCmd,
  output logic [7:0]        hostRdata
);
  localparam logic [ADDR_W-1:0] DATA_PORT = CFG_PORT + ADDR_W'(1);

  logic       unlocked;
  logic [7:0] idxReg;
  logic       isIdx;
  logic       isData;

  assign isIdx  = (hostAddr == CFG_PORT);
  assign isData = (hostAddr == DATA_PORT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      unlocked <= 1'b0;
      idxReg   <= 8'h00;
    end else if (hostWr && isIdx) begin
      if (!unlocked) begin
        if (hostWdata == KEY_OPEN) unlocked <= 1'b1;
      end else if (hostWdata == KEY_CLOSE) begin
        unlocked <= 1'b0;
      end else begin
        idxReg <= hostWdata;
      end
    end
  end

  always_comb begin
    cfgCmd.wrEn  = unlocked && hostWr && isData;
    cfgCmd.idx   = idxReg;
    cfgCmd.wdata = hostWdata;
  end

  always_comb begin
    hostRdata = 8'h00;
    if (hostRd) begin
      if (isIdx)       hostRdata = unlocked ? idxReg : 8'hFF;
      else if (isData) hostRdata = unlocked ? regRdata : 8'hFF;
    end
  end

  AST_UNLOCK_ON_KEY: assert property (@(posedge clk) disable iff (!rstN)
    (!unlocked && hostWr && isIdx && hostWdata == KEY_OPEN) |=> unlocked); // R2
  AST_LOCKED_NO_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    (!unlocked && !(hostWr && isIdx)) |=> !cfgCmd.wrEn || $past(unlocked)); // R2
  AST_CLOSE_KEY_LOCKS: assert property (@(posedge clk) disable iff (!rstN)
    (unlocked && hostWr && isIdx && hostWdata == KEY_CLOSE) |=> (!unlocked && $stable(idxReg))); // R3
endmodule

// File: rtl/sio_cfg_regs.sv
module sio_cfg_regs
  import sio_cfg_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  cfgCmd_t                        cfgCmd,
  input  logic [ADDR_W-1:0]              hostAddr,
  output logic [7:0]                     regRdata,
  output logic [NUM_DEV-1:0][ADDR_W-1:0] devBase,
  output logic [NUM_DEV-1:0][3:0]        devIrq,
  output logic [3:0]                     ppDrq,
  output logic [NUM_DEV-1:0]             devActive,
  output logic [NUM_DEV-1:0]             devSel
);
  localparam int PAD_W = ADDR_W - 10;

  logic [7:0] pwrA, pwrB, dmaPp, irqPp, irqSp;
  logic [NUM_DEV-1:0][7:0] baseReg;
  logic [NUM_DEV-1:0]      pwrBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pwrA    <= '0;
      pwrB    <= '0;
      dmaPp   <= '0;
      irqPp   <= '0;
      irqSp   <= '0;
      baseReg <= '0;
    end else if (cfgCmd.wrEn) begin
      case (cfgCmd.idx)
        IDX_PWR_A:  pwrA  <= cfgCmd.wdata;
        IDX_PWR_B:  pwrB  <= cfgCmd.wdata;
        IDX_DMA_PP: dmaPp <= cfgCmd.wdata;
        IDX_IRQ_PP: irqPp <= cfgCmd.wdata;
        IDX_IRQ_SP: irqSp <= cfgCmd.wdata;
        default: begin
          for (int d = 0; d < NUM_DEV; d++)
            if (cfgCmd.idx == IDX_BASE0 + 8'(d)) baseReg[d] <= cfgCmd.wdata;
        end
      endcase
    end
  end

  always_comb begin
    regRdata = 8'h00;
    case (cfgCmd.idx)
      IDX_PWR_A:  regRdata = pwrA;
      IDX_PWR_B:  regRdata = pwrB;
      IDX_DMA_PP: regRdata = dmaPp;
      IDX_IRQ_PP: regRdata = irqPp;
      IDX_IRQ_SP: regRdata = irqSp;
      default: begin
        for (int d = 0; d < NUM_DEV; d++)
          if (cfgCmd.idx == IDX_BASE0 + 8'(d)) regRdata = baseReg[d];
      end
    endcase
  end

  assign pwrBit[DEV_PP]  = pwrA[2];
  assign pwrBit[DEV_SP1] = pwrB[3];
  assign pwrBit[DEV_SP2] = pwrB[7];

  assign devIrq[DEV_PP]  = irqPp[3:0];
  assign devIrq[DEV_SP1] = irqSp[7:4];
  assign devIrq[DEV_SP2] = irqSp[3:0];
  assign ppDrq           = dmaPp[3:0];

  for (genvar g = 0; g < NUM_DEV; g++) begin : g_dev
    localparam int WIN_LSB = (g == DEV_PP) ? 2 : 3;
    logic inWin;
    assign devBase[g]   = {{PAD_W{1'b0}}, baseReg[g], 2'b00};
    assign devActive[g] = pwrBit[g] && (baseReg[g] != 8'h00);
    assign inWin        = (hostAddr[ADDR_W-1:WIN_LSB] == devBase[g][ADDR_W-1:WIN_LSB]);
    assign devSel[g]    = devActive[g] && inWin;

    AST_SEL_NEEDS_BASE: assert property (@(posedge clk) disable iff (!rstN)
      devSel[g] |-> (devBase[g] != '0)); // R9
  end

  AST_IDLE_HOLDS_REGS: assert property (@(posedge clk) disable iff (!rstN)
    !cfgCmd.wrEn |=> ($stable(baseReg) && $stable(irqSp) && $stable(pwrB))); // R2
  AST_SP_IRQ_LANDS: assert property (@(posedge clk) disable iff (!rstN)
    (cfgCmd.wrEn && cfgCmd.idx == IDX_IRQ_SP) |=> (devIrq[DEV_SP1] == $past(cfgCmd.wdata[7:4]))); // R6
endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port
  import sio_cfg_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] CFG_PORT = 'h2E
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              hostWr,
  input  logic              hostRd,
  input  logic [7:0]        hostWdata,
  output logic [7:0]        hostRdata,
  output logic [ADDR_W-1:0] ppBase,
  output logic [ADDR_W-1:0] sp1Base,
  output logic [ADDR_W-1:0] sp2Base,
  output logic [3:0]        ppIrq,
  output logic [3:0]        sp1Irq,
  output logic [3:0]        sp2Irq,
  output logic [3:0]        ppDrq,
  output logic              ppActive,
  output logic              sp1Active,
  output logic              sp2Active,
  output logic              ppSel,
  output logic              sp1Sel,
  output logic              sp2Sel
);
  cfgCmd_t                        cfgCmd;
  logic [7:0]                     regRdata;
  logic [NUM_DEV-1:0][ADDR_W-1:0] devBase;
  logic [NUM_DEV-1:0][3:0]        devIrq;
  logic [NUM_DEV-1:0]             devActive;
  logic [NUM_DEV-1:0]             devSel;

  sio_cfg_ctrl #(.ADDR_W(ADDR_W), .CFG_PORT(CFG_PORT)) ctrl_i (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostWr(hostWr),
    .hostRd(hostRd), .hostWdata(hostWdata), .regRdata(regRdata),
    .cfgCmd(cfgCmd), .hostRdata(hostRdata)
  );

  sio_cfg_regs #(.ADDR_W(ADDR_W)) regs_i (
    .clk(clk), .rstN(rstN), .cfgCmd(cfgCmd), .hostAddr(hostAddr),
    .regRdata(regRdata), .devBase(devBase), .devIrq(devIrq),
    .ppDrq(ppDrq), .devActive(devActive), .devSel(devSel)
  );

  assign ppBase    = devBase[DEV_PP];
  assign sp1Base   = devBase[DEV_SP1];
  assign sp2Base   = devBase[DEV_SP2];
  assign ppIrq     = devIrq[DEV_PP];
  assign sp1Irq    = devIrq[DEV_SP1];
  assign sp2Irq    = devIrq[DEV_SP2];
  assign ppActive  = devActive[DEV_PP];
  assign sp1Active = devActive[DEV_SP1];
  assign sp2Active = devActive[DEV_SP2];
  assign ppSel     = devSel[DEV_PP];
  assign sp1Sel    = devSel[DEV_SP1];
  assign sp2Sel    = devSel[DEV_SP2];

  AST_ACTIVE_NEEDS_POWER: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sp2Active) |-> (sp2Base != '0)); // R8
endmodule

// File: tb/sio_cfg_port_tb.sv
module sio_cfg_port_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] IDXP = 16'h002E;
  localparam logic [15:0] DATP = 16'h002F;

  logic clk = 1'b0, rstN = 1'b0, hostWr = 1'b0, hostRd = 1'b0;
  logic [15:0] hostAddr = '0;
  logic [7:0] hostWdata = '0, hostRdata;
  logic [15:0] ppBase, sp1Base, sp2Base;
  logic [3:0] ppIrq, sp1Irq, sp2Irq, ppDrq;
  logic ppActive, sp1Active, sp2Active, ppSel, sp1Sel, sp2Sel;
  int checks = 0, failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sio_cfg_port dut_i (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostWr(hostWr), .hostRd(hostRd),
    .hostWdata(hostWdata), .hostRdata(hostRdata), .ppBase(ppBase), .sp1Base(sp1Base),
    .sp2Base(sp2Base), .ppIrq(ppIrq), .sp1Irq(sp1Irq), .sp2Irq(sp2Irq), .ppDrq(ppDrq),
    .ppActive(ppActive), .sp1Active(sp1Active), .sp2Active(sp2Active),
    .ppSel(ppSel), .sp1Sel(sp1Sel), .sp2Sel(sp2Sel)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [15:0] a, logic [7:0] d);
    @(negedge clk); hostAddr = a; hostWdata = d; hostWr = 1'b1;
    @(negedge clk); hostWr = 1'b0; hostAddr = 16'h0000;
  endtask

  task automatic rd(logic [15:0] a, output logic [7:0] d);
    @(negedge clk); hostAddr = a; hostRd = 1'b1;
    #1 d = hostRdata;
    hostRd = 1'b0; hostAddr = 16'h0000;
  endtask

  task automatic regWr(logic [7:0] i, logic [7:0] d);
    wr(IDXP, i); wr(DATP, d);
  endtask

  task automatic regRd(logic [7:0] i, output logic [7:0] d);
    wr(IDXP, i); rd(DATP, d);
  endtask

  task automatic addrAt(logic [15:0] a);
    @(negedge clk); hostAddr = a; #1;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    chk("R1 ppBase", ppBase, 0); chk("R1 sp1Base", sp1Base, 0); chk("R1 sp2Base", sp2Base, 0);
    chk("R1 irqs", {ppIrq, sp1Irq, sp2Irq, ppDrq}, 0);
    chk("R1 active", {ppActive, sp1Active, sp2Active}, 0);
    chk("R1 sel", {ppSel, sp1Sel, sp2Sel}, 0);
    rd(DATP, v); chk("R1 locked data read", v, 8'hFF);
  endtask

  task automatic t_locked();
    logic [7:0] v;
    wr(IDXP, 8'h24); wr(DATP, 8'h12);
    rd(DATP, v); chk("R2 locked data read", v, 8'hFF);
    rd(IDXP, v); chk("R11 locked index read", v, 8'hFF);
    wr(IDXP, 8'h55);
    rd(IDXP, v); chk("R2 index write ignored while locked", v, 8'h00);
    regRd(8'h24, v); chk("R2 data write ignored while locked", v, 8'h00);
    chk("R2 sp1Base untouched", sp1Base, 0);
  endtask

  task automatic t_base();
    logic [7:0] v;
    regWr(8'h23, 8'hDE); regWr(8'h24, 8'hFE); regWr(8'h25, 8'hBE);
    chk("R4 ppBase", ppBase, 16'h0378);
    chk("R4 sp1Base", sp1Base, 16'h03F8);
    chk("R4 sp2Base", sp2Base, 16'h02F8);
    regRd(8'h24, v); chk("R4 readback", v, 8'hFE);
    chk("R8 no power no active", {ppActive, sp1Active, sp2Active}, 0);
  endtask

  task automatic t_irqdma();
    logic [7:0] v;
    regWr(8'h26, 8'hA5); chk("R5 ppDrq", ppDrq, 4'h5);
    regRd(8'h26, v); chk("R5 upper bits kept", v, 8'hA5);
    regWr(8'h27, 8'h37); chk("R6 ppIrq", ppIrq, 4'h7);
    regWr(8'h28, 8'h4C);
    chk("R6 sp1Irq", sp1Irq, 4'h4); chk("R6 sp2Irq", sp2Irq, 4'hC);
  endtask

  task automatic t_power();
    logic [7:0] v;
    regWr(8'h01, 8'h04); regWr(8'h02, 8'h08);
    chk("R7 pp/sp1 power", {ppActive, sp1Active, sp2Active}, 3'b110);
    regRd(8'h02, v); chk("R7 readback", v, 8'h08);
    regWr(8'h25, 8'h00); regWr(8'h02, 8'h88);
    chk("R8 zero base stays inactive", sp2Active, 1'b0);
    addrAt(16'h0000); chk("R8 zero base no select", sp2Sel, 1'b0);
    regWr(8'h25, 8'hBE); chk("R8 based and powered", sp2Active, 1'b1);
    regWr(8'h01, 8'hFB); chk("R8 pp power clear", ppActive, 1'b0);
    regWr(8'h01, 8'h04);
  endtask

  task automatic t_decode();
    addrAt(16'h03F8); chk("R9 sp1 window start", {ppSel, sp1Sel, sp2Sel}, 3'b010);
    addrAt(16'h03FF); chk("R9 sp1 window end", sp1Sel, 1'b1);
    addrAt(16'h0400); chk("R9 sp1 past window", sp1Sel, 1'b0);
    addrAt(16'h037B); chk("R9 pp window end", ppSel, 1'b1);
    addrAt(16'h037C); chk("R9 pp 4-byte window", ppSel, 1'b0);
    addrAt(16'h02FC); chk("R9 sp2 window", sp2Sel, 1'b1);
    addrAt(16'h0000);
    regWr(8'h02, 8'h80);
    addrAt(16'h03F9); chk("R9 unpowered no select", sp1Sel, 1'b0);
    addrAt(16'h0000);
  endtask

  task automatic t_unimpl();
    logic [7:0] v;
    regWr(8'h10, 8'h77);
    rd(DATP, v); chk("R10 unimplemented read", v, 8'h00);
    regRd(8'h28, v); chk("R10 no side effect", v, 8'h4C);
  endtask

  task automatic t_relock();
    logic [7:0] v;
    wr(IDXP, 8'h28);
    rd(IDXP, v); chk("R11 unlocked index read", v, 8'h28);
    wr(IDXP, 8'hAA);
    rd(IDXP, v); chk("R3 locked after close key", v, 8'hFF);
    wr(DATP, 8'h11);
    chk("R3 write after close ignored", {sp1Irq, sp2Irq}, 8'h4C);
    wr(IDXP, 8'h55);
    rd(IDXP, v); chk("R3 index kept, 0xAA not selected", v, 8'h28);
    wr(IDXP, 8'hAA);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_locked();
    t_base();
    t_irqdma();
    t_power();
    t_decode();
    t_unimpl();
    wr(IDXP, 8'h00);
    t_relock();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule